// File: doc/BRIEF.md
# Sigma-Delta DAC Interpolation Chain

This block takes audio-band samples (16-bit two's complement) arriving at the channel sample rate and produces a stream at 64 times that rate, ready for a digital noise-shaping modulator. The upsampling happens in two steps. A polyphase FIR stage interpolates by 4 with a triangular kernel, which is linear interpolation between consecutive input samples. A second-order sinc (CIC) stage then interpolates by 16, stuffing zeros between samples, and divides by its DC gain of 16 so that the DC gain of the whole chain stays at one. The sinc result is clamped to the 16-bit range before it leaves the block.

The system supplies one high-rate enable pulse (`hr_en`) per output slot. The chain counts these pulses from reset and takes the value held in its sample register on a fixed grid of pulses. A write strobe (`in_valid`) only loads that register. With `fir_bypass` set, the FIR stage is taken out of the path and samples are taken four times as often. The sinc stage stays in use in both modes. `fir_bypass` is expected to change only while reset is asserted.

Top module: `sdm_interp`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `hr_en` pulse, `out_data` is 0 and `out_valid` is 0.
- R2: `out_valid` is 1 in exactly those cycles that follow a cycle with `hr_en` = 1, and 0 otherwise.
- R3: `out_data` changes only at clock edges where `hr_en` = 1.
- R4: With `fir_bypass` = 0, counting `hr_en` pulses from 0 after reset, the sample register is taken at pulses p with p mod 64 = 63. For a sample S taken at pulse 63 after reset, with nothing taken before it, `out_data` stays 0 through pulse 78 and first moves after pulse 79.
- R5: With `fir_bypass` = 0, let X[m] be the sample taken at pulse 64m+63, with X[m] = 0 for m < 0. The FIR value F[b] for block b (pulses 16b..16b+15) is floor(((k+1)·X[j] + (3−k)·X[j−1]) / 4), where k = b mod 4 and j = floor(b/4) − 1.
- R6: The sinc output after pulse 16b+15+q, for q = 0..15, is floor(((q+1)·F[b] + (15−q)·F[b−1]) / 16), with F[−1] = 0. A sample repeated over three periods therefore appears exactly at the output (unity DC gain).
- R7: With `fir_bypass` = 1, the sample register is taken at every pulse p with p mod 16 = 15. F[b+1] equals the sample taken at pulse 16b+15, with F[0] = 0, so the FIR is out of the path.
- R8: With `fir_bypass` = 1 the sinc stage is still active. An input step reaches the output as a 16-step ramp, and two consecutive output words never differ by more than 2^16/16 + 1 = 4097.
- R9: A cycle with `in_valid` = 1 writes `in_data` to the sample register. The last write before a take pulse is the one used. A write alone does not change `out_data`.
- R10: `out_data` is clamped to [−32768, 32767]. Full-scale inputs of either sign reach the output exactly, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fir_bypass | input | 1 | 1 removes the FIR stage; samples are then taken every 16 pulses |
| in_valid | input | 1 | Writes `in_data` into the sample register |
| in_data | input | 16 | Input sample, two's complement |
| hr_en | input | 1 | High-rate enable, one pulse per output slot |
| out_valid | output | 1 | Marks the cycle after each `hr_en` pulse |
| out_data | output | 16 | High-rate output sample, two's complement |

## Verification
Every output word is a fixed mix of two sinc inputs, and each sinc input is a fixed mix of two taken samples. A corrupted comb delay, integrator or FIR history register therefore shows up as a wrong `out_data` on the very next `hr_en` pulse after it is first used, and in the worst case within one sample period (64 pulses). A slip in the pulse counters or the phase counter moves the take pulse or the interpolation weights. That shows up as output steps of the wrong size or at the wrong slot within the following block of 16 pulses. Because the bench compares every pulse against a model that tracks the take times, the fault is caught at the first output slot where the values differ.

// File: rtl/sdm_interp_pkg.sv
package sdm_interp_pkg;

   // order of the sinc (CIC) interpolator; its compensation shift is derived from it
   localparam int unsigned SINC_ORDER = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sdm_interp_pacer.sv
module sdm_interp_pacer #(
   parameter int unsigned FIR_R  = 4,
   parameter int unsigned SINC_R = 16,
   localparam int unsigned FIR_LG  = $clog2(FIR_R),
   localparam int unsigned SINC_LG = $clog2(SINC_R)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hr_en,
   input  logic              fir_bypass,
   output logic              blk_end,
   output logic              fir_take,
   output logic [FIR_LG-1:0] fir_phase
);

   logic [SINC_LG-1:0] slot_q;

   // last pulse of every sinc block of SINC_R slots
   assign blk_end  = hr_en && (slot_q == SINC_LG'(SINC_R - 1));
   assign fir_take = blk_end && (fir_bypass || (fir_phase == FIR_LG'(FIR_R - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q    <= '0;
         fir_phase <= '0;
      end else begin
         if (hr_en)   slot_q    <= slot_q + 1'b1;
         if (blk_end) fir_phase <= fir_phase + 1'b1;
      end
   end

endmodule

// File: rtl/sdm_interp_fir.sv
module sdm_interp_fir #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned FIR_R  = 4,
   localparam int unsigned FIR_LG = $clog2(FIR_R),
   localparam int unsigned PW     = DATA_W + FIR_LG + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic                     fir_bypass,
   input  logic [FIR_LG-1:0]        phase,
   input  logic signed [DATA_W-1:0] sample_in,
   output logic signed [DATA_W-1:0] fir_out
);

   logic signed [DATA_W-1:0] x_cur, x_prev;
   logic signed [PW-1:0]     w_cur, w_prev, acc, lin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_cur  <= '0;
         x_prev <= '0;
      end else if (take) begin
         x_prev <= x_cur;
         x_cur  <= sample_in;
      end
   end

   // polyphase triangular kernel: phase k weighs the newest sample by k+1
   always_comb begin
      w_cur  = PW'(phase) + PW'(1);
      w_prev = PW'(FIR_R - 1) - PW'(phase);
      acc    = w_cur * PW'(x_cur) + w_prev * PW'(x_prev);
      lin    = acc >>> FIR_LG;
      fir_out = fir_bypass ? x_cur : lin[DATA_W-1:0];
   end

endmodule

// File: rtl/sdm_interp_sinc.sv
module sdm_interp_sinc
   import sdm_interp_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SINC_R = 16,
   parameter int unsigned ORDER  = SINC_ORDER,
   localparam int unsigned SINC_LG = $clog2(SINC_R),
   localparam int unsigned SHIFT   = (ORDER - 1) * SINC_LG,
   localparam int unsigned ACC_W   = DATA_W + SHIFT + ORDER
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hr_en,
   input  logic                     blk_end,
   input  logic signed [DATA_W-1:0] u_in,
   output logic signed [DATA_W-1:0] y_out
);

   localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

   logic signed [ACC_W-1:0] cd [ORDER+1];
   logic signed [ACC_W-1:0] cz [ORDER];
   logic signed [ACC_W-1:0] ig [ORDER];
   logic signed [ACC_W-1:0] is [ORDER];
   logic signed [ACC_W-1:0] stuffed, scaled;

   assign cd[0]   = ACC_W'(u_in);
   assign stuffed = blk_end ? cd[ORDER] : '0;

   // comb sections run once per block, integrators once per pulse
   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      assign cd[g+1] = cd[g] - cz[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cz[g] <= '0;
         else if (blk_end) cz[g] <= cd[g];
      end

      if (g == 0) begin : g_first
         assign is[g] = ig[g] + stuffed;
      end else begin : g_next
         assign is[g] = ig[g] + is[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ig[g] <= '0;
         else if (hr_en) ig[g] <= is[g];
      end
   end

   // gain compensation by shift, then clamp to the output range
   always_comb begin
      scaled = ig[ORDER-1] >>> SHIFT;
      if (scaled > HI)      y_out = HI[DATA_W-1:0];
      else if (scaled < LO) y_out = LO[DATA_W-1:0];
      else                  y_out = scaled[DATA_W-1:0];
   end

endmodule

// File: rtl/sdm_interp.sv
module sdm_interp
   import sdm_interp_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned RATE   = 64,
   parameter int unsigned FIR_R  = 4,
   parameter int unsigned SINC_R = 16,
   localparam int unsigned FIR_LG = $clog2(FIR_R)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fir_bypass,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              hr_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   if (!is_pow2(FIR_R) || !is_pow2(SINC_R) || FIR_R < 2 || SINC_R < 2) begin : g_bad_ratio
      $error("sdm_interp: FIR_R and SINC_R must be powers of two, at least 2");
   end
   if (FIR_R * SINC_R != RATE) begin : g_bad_rate
      $error("sdm_interp: FIR_R * SINC_R must equal RATE");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("sdm_interp: DATA_W too small");
   end

   logic signed [DATA_W-1:0] held_q, fir_y, sinc_y;
   logic                     blk_end, fir_take;
   logic [FIR_LG-1:0]        fir_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= '0;
         out_valid <= 1'b0;
      end else begin
         if (in_valid) held_q <= in_data;
         out_valid <= hr_en;
      end
   end

   sdm_interp_pacer #(.FIR_R(FIR_R), .SINC_R(SINC_R)) i_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .hr_en      (hr_en),
      .fir_bypass (fir_bypass),
      .blk_end    (blk_end),
      .fir_take   (fir_take),
      .fir_phase  (fir_phase)
   );

   sdm_interp_fir #(.DATA_W(DATA_W), .FIR_R(FIR_R)) i_fir (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (fir_take),
      .fir_bypass (fir_bypass),
      .phase      (fir_phase),
      .sample_in  (held_q),
      .fir_out    (fir_y)
   );

   sdm_interp_sinc #(.DATA_W(DATA_W), .SINC_R(SINC_R)) i_sinc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hr_en   (hr_en),
      .blk_end (blk_end),
      .u_in    (fir_y),
      .y_out   (sinc_y)
   );

   assign out_data = sinc_y;

endmodule

// File: rtl/sdm_interp_chk.sv
module sdm_interp_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SINC_R = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     hr_en,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data
);

   localparam int STEP_MAX = (2 ** DATA_W) / SINC_R + 1;

   logic signed [DATA_W-1:0] prev_out;
   int                       diff, mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev_out <= '0;
      else if (out_valid) prev_out <= out_data;
   end

   always_comb begin
      diff = int'(out_data) - int'(prev_out);
      mag  = (diff < 0) ? -diff : diff;
   end

   // R2
   a_r2_valid_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hr_en |=> out_valid);

   // R2
   a_r2_no_valid_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !hr_en |=> !out_valid);

   // R3
   a_r3_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      !hr_en |=> $stable(out_data));

   // R8
   a_r8_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mag <= STEP_MAX));

endmodule

bind sdm_interp sdm_interp_chk #(.DATA_W(DATA_W), .SINC_R(SINC_R)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hr_en     (hr_en),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_sdm_interp.sv
module test_sdm_interp;

   localparam int CLK_P = 10;
   localparam int NVEC  = 10;
   // {fir_bypass, sample}
   localparam logic [16:0] VECS [NVEC] = '{
      {1'b0, 16'(1000)},   {1'b0, 16'(1000)},  {1'b0, 16'(-20000)},
      {1'b0, 16'(32767)},  {1'b0, 16'(-32768)}, {1'b0, 16'(12345)},
      {1'b1, 16'(500)},    {1'b1, 16'(-32768)}, {1'b1, 16'(32767)},
      {1'b1, 16'(7)}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fir_bypass = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        hr_en = 1'b0;
   logic        out_valid;
   logic [15:0] out_data;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 1'b0;
   string cur_tag  = "R5";

   // reference model state
   int m_p, m_held, xc, xp, f_cur, cc, cp, last_exp;
   bit m_byp;

   sdm_interp i_sdm_interp (
      .clk        (clk),
      .rst_n      (rst_n),
      .fir_bypass (fir_bypass),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .hr_en      (hr_en),
      .out_valid  (out_valid),
      .out_data   (out_data)
   );

   always #(CLK_P / 2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (pulse %0d)", tag, act, exp, m_p);
      end
   endtask

   function automatic void model_reset(input bit b);
      m_p = 0; m_held = 0; xc = 0; xp = 0; f_cur = 0; cc = 0; cp = 0;
      last_exp = 0; m_byp = b;
   endfunction

   function automatic int model_step();
      int slot, blk, kn, pos;
      slot = m_p % 16;
      blk  = m_p / 16;
      if (slot == 15) begin
         cp = cc;
         cc = f_cur;
         if (m_byp) begin
            f_cur = m_held;
         end else begin
            if (blk % 4 == 3) begin
               xp = xc;
               xc = m_held;
            end
            kn = (blk + 1) % 4;
            f_cur = ((kn + 1) * xc + (3 - kn) * xp) >>> 2;
         end
      end
      pos = (slot + 1) % 16;
      m_p++;
      last_exp = ((pos + 1) * cc + (15 - pos) * cp) >>> 4;
      return last_exp;
   endfunction

   task automatic do_reset(input bit b);
      rst_n = 1'b0; fir_bypass = b; hr_en = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", int'($signed(out_data)), 0);
      chk("R1", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'($signed(out_data)), 0);
      chk("R1", int'(out_valid), 0);
      model_reset(b);
   endtask

   task automatic load(input int v);
      in_valid = 1'b1;
      in_data  = 16'(v);
      @(negedge clk);
      in_valid = 1'b0;
      m_held   = v;
      chk("R9", int'($signed(out_data)), last_exp);
      chk("R2", int'(out_valid), 0);
   endtask

   task automatic pulse();
      int e;
      hr_en = 1'b1;
      @(negedge clk);
      hr_en = 1'b0;
      e = model_step();
      chk(cur_tag, int'($signed(out_data)), e);
      chk("R2", int'(out_valid), 1);
      if (m_p % 3 == 0) begin
         @(negedge clk);
         chk("R2", int'(out_valid), 0);
         chk("R3", int'($signed(out_data)), e);
      end
   endtask

   initial begin
      int mode = -1;
      @(negedge clk);
      // vector table walk: R5 in normal mode, R7 in bypass mode
      for (int i = 0; i < NVEC; i++) begin
         bit b = VECS[i][16];
         if (int'(b) != mode) begin
            do_reset(b);
            mode = int'(b);
         end
         cur_tag = b ? "R7" : "R5";
         load(int'($signed(VECS[i][15:0])));
         repeat (b ? 16 : 64) pulse();
      end

      // R4: take grid and first movement of the output
      do_reset(1'b0);
      cur_tag = "R4";
      load(16384);
      repeat (128) pulse();

      // R6: repeated sample appears exactly at the output
      do_reset(1'b0);
      cur_tag = "R6";
      repeat (3) begin
         load(1000);
         repeat (64) pulse();
      end
      chk("R6", int'($signed(out_data)), 1000);

      // R9: the later of two writes is the one taken
      do_reset(1'b0);
      cur_tag = "R9";
      load(500);
      load(-300);
      repeat (128) pulse();

      // R8: bypass step becomes a 16-step ramp
      do_reset(1'b1);
      cur_tag = "R8";
      load(1600);
      repeat (48) pulse();
      chk("R8", int'($signed(out_data)), 1600);

      // R10: full scale of both signs, no wrap
      do_reset(1'b1);
      cur_tag = "R10";
      repeat (3) begin
         load(32767);
         repeat (16) pulse();
      end
      chk("R10", int'($signed(out_data)), 32767);
      repeat (3) begin
         load(-32768);
         repeat (16) pulse();
      end
      chk("R10", int'($signed(out_data)), -32768);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule